// File: doc/BRIEF.md
# Two-Thread Back-End Slot Allocator

This block sits between the per-thread micro-op queues of a two-way multithreaded core and its out-of-order back end. Each cycle it looks at the head micro-op offered by each hardware thread and grants at most one of them. The grant claims a reorder slot, plus a load-buffer slot and/or a store-buffer slot if the micro-op needs one. It returns the winning thread and the slot indices, and pops that thread's queue through a one-hot take signal.

Every pool is split into two equal halves, one per thread. A thread can never hold more than its half, so neither thread can starve the other or deadlock it. When both threads can go, the grant alternates every clock. When one thread is halted, stalled, has nothing valid or is at its cap in a pool it needs, the other thread is served on consecutive cycles. Retirement returns slots through per-thread, per-pool release pulses, one slot per pulse, oldest first.

Top module: `smt_alloc`

## Requirements
- R1: While reset is held and afterwards, every thread's occupancy is zero. With no valid micro-op, alloc_vld is low. The first cycle in which both threads are eligible after reset grants thread 0.
- R2: At most one micro-op is granted per cycle. uop_take is zero or one-hot, and its set bit equals alloc_tid whenever alloc_vld is high.
- R3: When both threads are eligible, the granted thread differs from the thread granted in the previous grant.
- R4: A thread with thr_halt or thr_stall high is never granted. The other thread is then granted on every cycle in which it is eligible.
- R5: Each thread may hold at most half of each pool (ROB_N/2, LD_N/2, ST_N/2). A thread at its cap in any pool its micro-op needs is not eligible.
- R6: uop_kind bit 0 set means the micro-op needs a load slot, and bit 1 set means it needs a store slot. Both bits may be set. alloc_ld and alloc_st read 0 unless the granted micro-op needs that pool.
- R7: A granted slot index equals tid times the pool's half size plus a per-thread position. That position starts at 0, advances by one per grant in that pool and wraps to 0 after half-1. alloc_rob, alloc_ld, alloc_st and alloc_tid read 0 when alloc_vld is low.
- R8: A release pulse lowers that thread's occupancy of that pool by one. A release and a grant in the same cycle leave the occupancy unchanged. Eligibility uses the occupancy held at the start of the cycle, so a release helps a full thread only from the next cycle on.
- R9: A release pulse for a pool in which the thread holds no slot is ignored.
- R10: When no thread is eligible, alloc_vld is low and uop_take is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_valid | input | 2 | Head micro-op present, one bit per thread |
| uop_kind | input | 4 | Pool needs per thread; bits [1:0] thread 0, [3:2] thread 1 |
| thr_halt | input | 2 | Thread halted |
| thr_stall | input | 2 | Thread stalled |
| rel_rob | input | 2 | Free one reorder slot of the thread |
| rel_ld | input | 2 | Free one load slot of the thread |
| rel_st | input | 2 | Free one store slot of the thread |
| uop_take | output | 2 | Pop the granted thread's queue |
| alloc_vld | output | 1 | A micro-op is granted this cycle |
| alloc_tid | output | 1 | Granted thread |
| alloc_rob | output | $clog2(ROB_N) | Reorder slot index |
| alloc_ld | output | $clog2(LD_N) | Load slot index |
| alloc_st | output | $clog2(ST_N) | Store slot index |

## Verification
The assertions assume that retirement never pulses a release for a slot the thread has not been granted, apart from the ignored pulse on an empty pool. They also assume that halt and stall are levels held from one cycle to the next. The bench meets these assumptions: it releases only slots it has counted as granted, and it sends exactly one deliberate release into an empty pool. The alternation property relies on the eligibility wires the top brings out, so the stimulus holds both threads eligible over runs of cycles, and that property is actually exercised.

// File: rtl/smt_alloc_pkg.sv
package smt_alloc_pkg;
  typedef logic [1:0] uop_kind_t;
  localparam int KIND_LD_BIT = 0;
  localparam int KIND_ST_BIT = 1;

  function automatic logic needs_ld(input uop_kind_t k);
    return k[KIND_LD_BIT];
  endfunction

  function automatic logic needs_st(input uop_kind_t k);
    return k[KIND_ST_BIT];
  endfunction

  // winner: the other thread on a tie, otherwise whichever is eligible
  function automatic logic pick_thread(input logic [1:0] elig, input logic last);
    if (elig == 2'b11) return ~last;
    return elig[1];
  endfunction
endpackage

// File: rtl/smt_alloc_pool.sv
module smt_alloc_pool #(
  parameter int HALF = 4,
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int CW = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          rel,
  output logic          room,
  output logic [PW-1:0] pos,
  output logic [CW-1:0] occ
);
  logic rel_ok;
  assign rel_ok = rel && (occ != '0);
  assign room   = (occ < CW'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      pos <= '0;
    end else begin
      case ({take, rel_ok})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
      if (take) pos <= (pos == PW'(HALF - 1)) ? '0 : pos + PW'(1);
    end
  end
endmodule

// File: rtl/smt_alloc_pick.sv
module smt_alloc_pick
  import smt_alloc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] elig,
  output logic [1:0] take,
  output logic       tid
);
  logic last;
  logic any;

  assign any  = |elig;
  assign tid  = pick_thread(elig, last);
  assign take = any ? (tid ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n)   last <= 1'b1;
    else if (any) last <= tid;
  end
endmodule

// File: rtl/smt_alloc.sv
module smt_alloc
  import smt_alloc_pkg::*;
#(
  parameter int ROB_N = 126,
  parameter int LD_N  = 48,
  parameter int ST_N  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               uop_valid,
  input  logic [3:0]               uop_kind,
  input  logic [1:0]               thr_halt,
  input  logic [1:0]               thr_stall,
  input  logic [1:0]               rel_rob,
  input  logic [1:0]               rel_ld,
  input  logic [1:0]               rel_st,
  output logic [1:0]               uop_take,
  output logic                     alloc_vld,
  output logic                     alloc_tid,
  output logic [$clog2(ROB_N)-1:0] alloc_rob,
  output logic [$clog2(LD_N)-1:0]  alloc_ld,
  output logic [$clog2(ST_N)-1:0]  alloc_st
);
  localparam int ROB_HALF = ROB_N / 2;
  localparam int LD_HALF  = LD_N / 2;
  localparam int ST_HALF  = ST_N / 2;
  localparam int RW  = $clog2(ROB_N);
  localparam int LW  = $clog2(LD_N);
  localparam int SW  = $clog2(ST_N);
  localparam int RPW = $clog2(ROB_HALF);
  localparam int LPW = $clog2(LD_HALF);
  localparam int SPW = $clog2(ST_HALF);
  localparam int RCW = $clog2(ROB_HALF + 1);
  localparam int LCW = $clog2(LD_HALF + 1);
  localparam int SCW = $clog2(ST_HALF + 1);

  // named internal events for the checker
  logic [1:0]           elig;
  logic [1:0]           grant_ld, grant_st;
  logic [1:0]           room_rob, room_ld, room_st;
  logic [1:0][RPW-1:0]  pos_rob;
  logic [1:0][LPW-1:0]  pos_ld;
  logic [1:0][SPW-1:0]  pos_st;
  logic [1:0][RCW-1:0]  occ_rob;
  logic [1:0][LCW-1:0]  occ_ld;
  logic [1:0][SCW-1:0]  occ_st;
  uop_kind_t            kind [2];

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign kind[t]     = uop_kind[2*t +: 2];
    assign elig[t]     = uop_valid[t] && !thr_halt[t] && !thr_stall[t] && room_rob[t]
                         && (!needs_ld(kind[t]) || room_ld[t])
                         && (!needs_st(kind[t]) || room_st[t]);
    assign grant_ld[t] = uop_take[t] && needs_ld(kind[t]);
    assign grant_st[t] = uop_take[t] && needs_st(kind[t]);

    smt_alloc_pool #(.HALF(ROB_HALF)) u_rob (
      .clk(clk), .rst_n(rst_n), .take(uop_take[t]), .rel(rel_rob[t]),
      .room(room_rob[t]), .pos(pos_rob[t]), .occ(occ_rob[t]));
    smt_alloc_pool #(.HALF(LD_HALF)) u_ld (
      .clk(clk), .rst_n(rst_n), .take(grant_ld[t]), .rel(rel_ld[t]),
      .room(room_ld[t]), .pos(pos_ld[t]), .occ(occ_ld[t]));
    smt_alloc_pool #(.HALF(ST_HALF)) u_st (
      .clk(clk), .rst_n(rst_n), .take(grant_st[t]), .rel(rel_st[t]),
      .room(room_st[t]), .pos(pos_st[t]), .occ(occ_st[t]));
  end

  smt_alloc_pick u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .take(uop_take), .tid(alloc_tid));

  assign alloc_vld = |uop_take;

  always_comb begin
    alloc_rob = '0;
    alloc_ld  = '0;
    alloc_st  = '0;
    if (alloc_vld) begin
      alloc_rob = (alloc_tid ? RW'(ROB_HALF) : RW'(0)) + RW'(pos_rob[alloc_tid]);
      if (grant_ld[alloc_tid])
        alloc_ld = (alloc_tid ? LW'(LD_HALF) : LW'(0)) + LW'(pos_ld[alloc_tid]);
      if (grant_st[alloc_tid])
        alloc_st = (alloc_tid ? SW'(ST_HALF) : SW'(0)) + SW'(pos_st[alloc_tid]);
    end
  end
endmodule

// File: rtl/smt_alloc_chk.sv
module smt_alloc_chk #(
  parameter int ROB_HALF = 63,
  parameter int RCW = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          uop_take,
  input logic                alloc_vld,
  input logic                alloc_tid,
  input logic [1:0]          elig,
  input logic [1:0]          thr_halt,
  input logic [1:0]          thr_stall,
  input logic [1:0]          rel_rob,
  input logic [1:0][RCW-1:0] occ_rob
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_onehot_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(uop_take));
  p_take_tid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |-> uop_take[alloc_tid]);
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(alloc_vld) && elig == 2'b11) |-> (alloc_tid != $past(alloc_tid)));
  p_halt_skip0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_halt[0] || thr_stall[0]) |-> !uop_take[0]);
  p_halt_skip1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_halt[1] || thr_stall[1]) |-> !uop_take[1]);
  p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ_rob[0]) <= ROB_HALF) && (int'(occ_rob[1]) <= ROB_HALF));
  p_full_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ_rob[0]) == ROB_HALF) |-> !uop_take[0]);
  p_rel_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_rob[1] == '0 && rel_rob[1] && !uop_take[1]) |=> (occ_rob[1] == '0));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == 2'b00) |-> !alloc_vld);
endmodule

bind smt_alloc smt_alloc_chk #(.ROB_HALF(ROB_HALF), .RCW(RCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .uop_take(uop_take), .alloc_vld(alloc_vld),
  .alloc_tid(alloc_tid), .elig(elig), .thr_halt(thr_halt), .thr_stall(thr_stall),
  .rel_rob(rel_rob), .occ_rob(occ_rob));

// File: tb/test_smt_alloc.sv
module test_smt_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int ROB_N = 8;   // half 4, thread 1 base 4
  localparam int LD_N  = 4;   // half 2, thread 1 base 2
  localparam int ST_N  = 4;   // half 2, thread 1 base 2

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] uop_valid = '0, thr_halt = '0, thr_stall = '0;
  logic [3:0] uop_kind = '0;
  logic [1:0] rel_rob = '0, rel_ld = '0, rel_st = '0;
  logic [1:0] uop_take;
  logic alloc_vld, alloc_tid;
  logic [2:0] alloc_rob;
  logic [1:0] alloc_ld, alloc_st;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_alloc #(.ROB_N(ROB_N), .LD_N(LD_N), .ST_N(ST_N)) i_smt_alloc (
    .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_kind(uop_kind),
    .thr_halt(thr_halt), .thr_stall(thr_stall), .rel_rob(rel_rob),
    .rel_ld(rel_ld), .rel_st(rel_st), .uop_take(uop_take),
    .alloc_vld(alloc_vld), .alloc_tid(alloc_tid), .alloc_rob(alloc_rob),
    .alloc_ld(alloc_ld), .alloc_st(alloc_st));

  // {vld, tid, rob[2:0], ld[1:0], st[1:0]} as one 9-bit word
  function automatic logic [8:0] result();
    return {alloc_vld, alloc_tid, alloc_rob, alloc_ld, alloc_st};
  endfunction

  function automatic logic [8:0] expect_word(input logic v, input logic t,
      input int r, input int l, input int s);
    return {v, t, 3'(r), 2'(l), 2'(s)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs settle after negedge, outputs sampled a quarter period later
  task automatic drive(input logic [1:0] v, input logic [3:0] k, input logic [1:0] h,
      input logic [1:0] s, input logic [1:0] rr, input logic [1:0] rl);
    @(negedge clk);
    uop_valid = v; uop_kind = k; thr_halt = h; thr_stall = s;
    rel_rob = rr; rel_ld = rl; rel_st = 2'b00;
    #(CLK_PERIOD/4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    uop_valid = '0; uop_kind = '0; thr_halt = '0; thr_stall = '0;
    rel_rob = '0; rel_ld = '0; rel_st = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // {valid, kind, halt, expected 9-bit result}
  localparam int NV = 10;
  localparam logic [16:0] VEC [NV] = '{
    {2'b11, 4'b0000, 2'b00, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0},
    {2'b11, 4'b0000, 2'b00, 1'b1, 1'b1, 3'd4, 2'd0, 2'd0},
    {2'b11, 4'b0001, 2'b00, 1'b1, 1'b0, 3'd1, 2'd0, 2'd0},
    {2'b11, 4'b1000, 2'b00, 1'b1, 1'b1, 3'd5, 2'd0, 2'd2},
    {2'b01, 4'b0011, 2'b00, 1'b1, 1'b0, 3'd2, 2'd1, 2'd0},
    {2'b01, 4'b0000, 2'b00, 1'b1, 1'b0, 3'd3, 2'd0, 2'd0},
    {2'b11, 4'b0000, 2'b00, 1'b1, 1'b1, 3'd6, 2'd0, 2'd0},
    {2'b11, 4'b0000, 2'b10, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0},
    {2'b10, 4'b0000, 2'b00, 1'b1, 1'b1, 3'd7, 2'd0, 2'd0},
    {2'b11, 4'b0000, 2'b00, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R10: idle after reset
    drive(2'b00, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R1 idle", {30'd0, uop_take}, 32'd0);
    check("R10 no grant", {23'd0, result()}, 32'd0);

    // table: R1 first tie, R3 alternation, R5 caps, R6 kinds, R7 indices, R4 halt
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16:15], VEC[i][14:11], VEC[i][10:9], 2'b00, 2'b00, 2'b00);
      check($sformatf("R3/R5/R6/R7 vector %0d", i), {23'd0, result()}, {23'd0, VEC[i][8:0]});
      if (alloc_vld) check("R2 take onehot", {30'd0, uop_take}, alloc_tid ? 32'd2 : 32'd1);
    end

    // R8: release with a full thread frees only from next cycle
    drive(2'b01, 4'b0000, 2'b00, 2'b00, 2'b01, 2'b00);
    check("R8 release same cycle", {23'd0, result()}, 32'd0);
    drive(2'b01, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R8 after release wraps R7", {23'd0, result()}, {23'd0, expect_word(1, 0, 0, 0, 0)});
    drive(2'b01, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R5 full again", {31'd0, alloc_vld}, 32'd0);

    // R9: release into an empty load pool is ignored
    do_reset();
    drive(2'b00, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b10);
    drive(2'b10, 4'b0100, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R9 first load", {23'd0, result()}, {23'd0, expect_word(1, 1, 4, 2, 0)});
    drive(2'b10, 4'b0100, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R9 second load", {23'd0, result()}, {23'd0, expect_word(1, 1, 5, 3, 0)});
    drive(2'b10, 4'b0100, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R5 load cap", {31'd0, alloc_vld}, 32'd0);
    drive(2'b10, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R6 plain passes load cap", {23'd0, result()}, {23'd0, expect_word(1, 1, 6, 0, 0)});

    // R8: grant and release in the same cycle net zero
    do_reset();
    for (int i = 0; i < 3; i++) begin
      drive(2'b01, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00);
      check("R7 sequential", {29'd0, alloc_rob}, 32'(i));
    end
    drive(2'b01, 4'b0000, 2'b00, 2'b00, 2'b01, 2'b00);
    check("R8 grant with release", {23'd0, result()}, {23'd0, expect_word(1, 0, 3, 0, 0)});
    drive(2'b01, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R8 net zero leaves room", {23'd0, result()}, {23'd0, expect_word(1, 0, 0, 0, 0)});
    drive(2'b01, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R8 then full", {31'd0, alloc_vld}, 32'd0);

    // R4: stalled thread 0, thread 1 served back to back, then tie goes to thread 0
    do_reset();
    for (int i = 0; i < 3; i++) begin
      drive(2'b11, 4'b0000, 2'b00, 2'b01, 2'b00, 2'b00);
      check("R4 stall back to back", {23'd0, result()}, {23'd0, expect_word(1, 1, 4 + i, 0, 0)});
    end
    drive(2'b11, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00);
    check("R3 tie after stall", {23'd0, result()}, {23'd0, expect_word(1, 0, 0, 0, 0)});
    drive(2'b11, 4'b0000, 2'b01, 2'b00, 2'b00, 2'b00);
    check("R4 halt thread 0", {23'd0, result()}, {23'd0, expect_word(1, 1, 7, 0, 0)});

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule